// File: doc/BRIEF.md
# Vector Lane Write-Masking Unit

This block sits just before vector register writeback and applies per-lane predication to a 512-bit result. A computed result vector arrives with a merge source vector, the index of one of eight predicate registers, a flag that picks merge or zeroing behaviour, and a lane-size select. Each lane whose predicate bit is set passes the computed value through. Each lane whose bit is clear either takes the matching lane of the merge source or becomes all zeros. A clear bit in merge mode keeps the old destination contents. The same predicate file can bound the tail of a loop whose trip count is not a multiple of the lane count: software clears the upper predicate bits.

The vector can be treated as 64 lanes of 8 bits or as 16 lanes of 32 bits, chosen per operation. The predicate file holds eight 64-bit registers and has its own write port. Index 0 is reserved to mean that every lane is enabled. The masked result is registered, with a valid/ready handshake on both sides.

Top module: `vmask_unit`

## Requirements
- R1: With `elemWide`=0 the vector is 64 byte lanes. Lane i is bits [8i+7:8i] and is controlled by bit i of the selected predicate register.
- R2: With `elemWide`=1 the vector is 16 lanes of 32 bits. Lane i is bits [32i+31:32i] and is controlled by predicate bit i. Predicate bits 63:16 have no effect on the output.
- R3: With `zeroMode`=0, a lane whose predicate bit is 0 outputs the matching lane of `mergeSrc`.
- R4: With `zeroMode`=1, a lane whose predicate bit is 0 outputs all zeros.
- R5: A lane whose predicate bit is 1 outputs the matching lane of `opResult` unchanged in both modes.
- R6: When `maskSel`=0, every lane is treated as enabled and the output equals `opResult`, whatever predicate register 0 holds.
- R7: When `mwrEn`=1, register `mwrIdx` takes `mwrData` at the clock edge. An operation accepted in the same cycle uses the value the register held before that write.
- R8: An operation accepted at edge N (`inValid`=1 and `inReady`=1) appears on `outData` with `outValid`=1 right after edge N. While `outValid`=1 and `outReady`=0, both `outValid` and `outData` hold.
- R9: `inReady` is 1 exactly when the output stage is empty or `outReady`=1. While `inReady`=0 an input is not taken.
- R10: A synchronous active-high `rst` clears `outValid` and every predicate register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An operation is presented |
| inReady | output | 1 | The unit can take an operation this cycle |
| opResult | input | 512 | Computed result vector |
| mergeSrc | input | 512 | Vector whose lanes are kept in merge mode |
| maskSel | input | 3 | Predicate register index; 0 means no masking |
| zeroMode | input | 1 | 1 = disabled lanes become zero, 0 = they take mergeSrc |
| elemWide | input | 1 | 1 = 32-bit lanes, 0 = 8-bit lanes |
| outValid | output | 1 | Masked result is available |
| outReady | input | 1 | Consumer takes the masked result |
| outData | output | 512 | Masked result vector |
| mwrEn | input | 1 | Predicate register write enable |
| mwrIdx | input | 3 | Predicate register written |
| mwrData | input | 64 | Value written to the predicate register |

## Verification
A masked result is due one clock edge after the operation is accepted. A predicate write takes effect for operations accepted at the edge after the write edge. The bench drives every input on the falling clock edge and reads `outData` and `outValid` on the following falling edge. Each check therefore sees exactly one rising edge after its stimulus. Under back-pressure the bench samples the held output over several falling edges, and it observes the second operation only on the falling edge after the edge at which `outReady` lets it in.

// File: rtl/vmask_pkg.sv
`timescale 1ns/1ps
package vmask_pkg;
  parameter int VEC_W    = 512;
  parameter int NUM_MASK = 8;
  parameter int MASK_W   = VEC_W / 8;
  parameter int IDX_W    = $clog2(NUM_MASK);

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic load;   // capture a new masked result
    logic busy;   // output stage currently holds a result
  } ctrlStrobes_t;
endpackage

// File: rtl/vmask_file.sv
`timescale 1ns/1ps
module vmask_file #(
  parameter int NUM_MASK = vmask_pkg::NUM_MASK,
  parameter int MASK_W   = vmask_pkg::MASK_W,
  parameter int IDX_W    = vmask_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [MASK_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [MASK_W-1:0] rdMask
);
  logic [NUM_MASK-1:0][MASK_W-1:0] maskRegs;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskRegs <= '0;
    end else if (wrEn) begin
      maskRegs[wrIdx] <= wrData;
    end
  end

  // index 0 is the "all lanes enabled" selector; its storage is never read
  always_comb begin
    if (rdIdx == '0) rdMask = '1;
    else             rdMask = maskRegs[rdIdx];
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> maskRegs[$past(wrIdx)] == $past(wrData));

  a_r10_file_cleared: assert property (@(posedge clk)
    rst |=> maskRegs == '0);
endmodule

// File: rtl/vmask_ctrl.sv
`timescale 1ns/1ps
module vmask_ctrl
  import vmask_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic validQ;
  logic accept;

  assign inReady  = !validQ || outReady;
  assign accept   = inValid && inReady;
  assign outValid = validQ;

  always_ff @(posedge clk) begin
    if (rst)           validQ <= 1'b0;
    else if (accept)   validQ <= 1'b1;
    else if (outReady) validQ <= 1'b0;
  end

  always_comb begin
    strobes.load = accept && !rst;
    strobes.busy = validQ;
  end

  a_r8_accept_valid: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> outValid);

  a_r8_hold_valid: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid);

  a_r8_drain: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !inValid |=> !outValid);

  a_r9_stall: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);
endmodule

// File: rtl/vmask_datapath.sv
`timescale 1ns/1ps
module vmask_datapath
  import vmask_pkg::*;
#(
  parameter int VEC_W  = vmask_pkg::VEC_W,
  parameter int MASK_W = vmask_pkg::MASK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [VEC_W-1:0]  opResult,
  input  logic [VEC_W-1:0]  mergeSrc,
  input  logic [MASK_W-1:0] laneMask,
  input  logic              zeroMode,
  input  logic              elemWide,
  output logic [VEC_W-1:0]  outData
);
  localparam int NBYTES  = VEC_W / 8;
  localparam int PER_WIDE = 4;

  logic [NBYTES-1:0] byteEn;
  logic [VEC_W-1:0]  nextData;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    // a wide lane spans four bytes that share one predicate bit
    assign byteEn[b] = elemWide ? laneMask[b / PER_WIDE] : laneMask[b];
    assign nextData[b*8 +: 8] = byteEn[b] ? opResult[b*8 +: 8]
                              : (zeroMode ? 8'h00 : mergeSrc[b*8 +: 8]);
  end

  always_ff @(posedge clk) begin
    if (strobes.load) outData <= nextData;
  end

  a_r5_all_pass: assert property (@(posedge clk) disable iff (rst)
    strobes.load && !elemWide && (laneMask == '1) |=> outData == $past(opResult));

  a_r3_all_merge: assert property (@(posedge clk) disable iff (rst)
    strobes.load && !zeroMode && (laneMask == '0) |=> outData == $past(mergeSrc));

  a_r4_all_zero: assert property (@(posedge clk) disable iff (rst)
    strobes.load && zeroMode && (laneMask == '0) |=> outData == '0);
endmodule

// File: rtl/vmask_unit.sv
`timescale 1ns/1ps
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int VEC_W    = vmask_pkg::VEC_W,
  parameter int NUM_MASK = vmask_pkg::NUM_MASK,
  parameter int MASK_W   = VEC_W / 8,
  parameter int IDX_W    = $clog2(NUM_MASK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [VEC_W-1:0]  opResult,
  input  logic [VEC_W-1:0]  mergeSrc,
  input  logic [IDX_W-1:0]  maskSel,
  input  logic              zeroMode,
  input  logic              elemWide,
  output logic              outValid,
  input  logic              outReady,
  output logic [VEC_W-1:0]  outData,
  input  logic              mwrEn,
  input  logic [IDX_W-1:0]  mwrIdx,
  input  logic [MASK_W-1:0] mwrData
);
  ctrlStrobes_t      strobes;
  logic [MASK_W-1:0] laneMask;

  vmask_file #(.NUM_MASK(NUM_MASK), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_file (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (mwrEn),
    .wrIdx (mwrIdx),
    .wrData(mwrData),
    .rdIdx (maskSel),
    .rdMask(laneMask)
  );

  vmask_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  vmask_datapath #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opResult(opResult),
    .mergeSrc(mergeSrc),
    .laneMask(laneMask),
    .zeroMode(zeroMode),
    .elemWide(elemWide),
    .outData (outData)
  );

  a_r6_sel_zero_pass: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && (maskSel == '0) |=> outData == $past(opResult));

  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> $stable(outData));
endmodule

// File: tb/sim_vmask_unit.sv
`timescale 1ns/1ps
module sim_vmask_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, outReady = 1'b1, zeroMode = 1'b0, elemWide = 1'b0;
  logic [511:0] opResult = '0, mergeSrc = '0;
  logic [2:0] maskSel = '0;
  logic mwrEn = 1'b0;
  logic [2:0] mwrIdx = '0;
  logic [63:0] mwrData = '0;
  logic inReady, outValid;
  logic [511:0] outData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [63:0] shadow [8];

  always #10 clk = ~clk;

  vmask_unit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .opResult(opResult), .mergeSrc(mergeSrc), .maskSel(maskSel),
    .zeroMode(zeroMode), .elemWide(elemWide), .outValid(outValid),
    .outReady(outReady), .outData(outData), .mwrEn(mwrEn),
    .mwrIdx(mwrIdx), .mwrData(mwrData)
  );

  // fields: predicate value, register index, zeroMode, elemWide
  localparam logic [68:0] VECS [8] = '{
    {64'hFFFF_FFFF_FFFF_FFFF, 3'd1, 1'b0, 1'b0},  // R5 all enabled
    {64'h0000_0000_0000_0000, 3'd1, 1'b0, 1'b0},  // R3 all merged
    {64'h0000_0000_0000_0000, 3'd2, 1'b1, 1'b0},  // R4 all zeroed
    {64'h5555_5555_5555_5555, 3'd3, 1'b0, 1'b0},  // R1 alternating bytes
    {64'h00FF_00FF_0F0F_F0F0, 3'd4, 1'b1, 1'b0},  // R1 R4 mixed
    {64'hFFFF_FFFF_FFFF_00F3, 3'd5, 1'b0, 1'b1},  // R2 upper bits ignored
    {64'h0000_0000_0000_7FFF, 3'd6, 1'b1, 1'b1},  // R2 tail of 15 lanes
    {64'h0000_0000_0000_0000, 3'd0, 1'b1, 1'b0}   // R6 reg 0 written, ignored
  };

  function automatic logic [511:0] model(logic [63:0] m, logic [2:0] sel, logic zero,
                                         logic wide, logic [511:0] r, logic [511:0] g);
    logic [511:0] e;
    logic en;
    for (int j = 0; j < 64; j++) begin
      en = (sel == 3'd0) ? 1'b1 : (wide ? m[j/4] : m[j]);
      e[j*8 +: 8] = en ? r[j*8 +: 8] : (zero ? 8'h00 : g[j*8 +: 8]);
    end
    return e;
  endfunction

  function automatic logic [511:0] mkData(int seed);
    logic [511:0] d;
    for (int j = 0; j < 64; j++) d[j*8 +: 8] = 8'(j*3 + seed*17 + 1);
    return d;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeMask(input logic [2:0] idx, input logic [63:0] val);
    @(negedge clk);
    mwrEn = 1'b1; mwrIdx = idx; mwrData = val;
    shadow[idx] = val;
    @(negedge clk);
    mwrEn = 1'b0;
  endtask

  task automatic runOp(input logic [2:0] sel, input logic zero, input logic wide,
                       input logic [511:0] r, input logic [511:0] g,
                       output logic [511:0] got, output logic gotValid);
    @(negedge clk);
    inValid = 1'b1; outReady = 1'b1; maskSel = sel; zeroMode = zero;
    elemWide = wide; opResult = r; mergeSrc = g;
    @(negedge clk);
    inValid = 1'b0;
    got = outData; gotValid = outValid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [511:0] got, r, g, e1, e2;
    logic gv;
    for (int k = 0; k < 8; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    chk("R10 outValid after reset", {511'b0, outValid}, '0);
    chk("R9 inReady when empty", {511'b0, inReady}, 512'b1);
    rst = 1'b0;

    // R10: predicates cleared, so register 3 disables everything
    r = mkData(40); g = ~r;
    runOp(3'd3, 1'b1, 1'b0, r, g, got, gv);
    chk("R10 cleared predicate zeroes", got, '0);
    chk("R8 valid one edge after accept", {511'b0, gv}, 512'b1);

    for (int i = 0; i < 8; i++) begin
      logic [63:0] m;
      logic [2:0] s;
      logic z, w;
      {m, s, z, w} = VECS[i];
      writeMask(s, m);
      r = mkData(i); g = ~mkData(i + 9);
      runOp(s, z, w, r, g, got, gv);
      chk($sformatf("R1 R2 R3 R4 R5 R6 vector %0d", i), got,
          model(shadow[s], s, z, w, r, g));
    end

    // R7: write and operation in the same cycle see the old predicate
    writeMask(3'd2, 64'h0);
    r = mkData(50); g = ~r;
    @(negedge clk);
    mwrEn = 1'b1; mwrIdx = 3'd2; mwrData = '1;
    inValid = 1'b1; outReady = 1'b1; maskSel = 3'd2; zeroMode = 1'b1;
    elemWide = 1'b0; opResult = r; mergeSrc = g;
    @(negedge clk);
    mwrEn = 1'b0; inValid = 1'b0;
    chk("R7 same-cycle uses old predicate", outData, '0);
    runOp(3'd2, 1'b1, 1'b0, r, g, got, gv);
    chk("R7 next operation uses new predicate", got, r);

    // R8/R9: back-pressure
    writeMask(3'd4, 64'h0000_0000_0000_00AA);
    r = mkData(60); g = mkData(61);
    e1 = model(shadow[4], 3'd4, 1'b0, 1'b0, r, g);
    @(negedge clk);
    inValid = 1'b1; outReady = 1'b0; maskSel = 3'd4; zeroMode = 1'b0;
    elemWide = 1'b0; opResult = r; mergeSrc = g;
    @(negedge clk);
    chk("R8 first result", outData, e1);
    chk("R9 stalled inReady", {511'b0, inReady}, '0);
    r = mkData(70); g = mkData(71);
    opResult = r; mergeSrc = g; zeroMode = 1'b1;
    e2 = model(shadow[4], 3'd4, 1'b1, 1'b0, r, g);
    @(negedge clk);
    chk("R8 data held under stall", outData, e1);
    chk("R8 valid held under stall", {511'b0, outValid}, 512'b1);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 second op taken after release", outData, e2);
    chk("R8 valid with second result", {511'b0, outValid}, 512'b1);
    @(negedge clk);
    chk("R8 valid drops when drained", {511'b0, outValid}, '0);

    // R10: reset clears predicates again and output valid
    writeMask(3'd5, '1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) shadow[k] = '0;
    chk("R10 valid cleared by reset", {511'b0, outValid}, '0);
    r = mkData(80); g = mkData(81);
    runOp(3'd5, 1'b0, 1'b1, r, g, got, gv);
    chk("R10 R3 predicate 5 cleared by reset", got, g);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule